// File: doc/BRIEF.md
# Pingable Countdown Watchdog with Reset Pulse

This block is an 8-bit countdown watchdog with a small register interface. Software arms it by writing a nonzero count into the value register. Each tick from the selected tick source lowers the count by one. Software keeps the system alive by rewriting the value register before the count runs out. A count of zero does not mean that the timer has expired. It means the watchdog is stopped, so a zero count never decrements and never fires.

When an armed count steps from one to zero, the block does three things:
- It raises a sticky watchdog flag at bit 6 of the status register.
- It leaves the counter stopped at zero.
- If reset routing is enabled, it drives the active-low reset output low for a fixed number of clock cycles.

Any read of the status register has a side effect: it clears the count to zero, which stops the watchdog. Software that polls status while the watchdog runs must therefore rewrite the value register afterwards.

Tick pulses arrive on a small vector of one-cycle strobes, one per source. The two-bit select field in the control register picks one of them. Setting 2'b10 picks entry 2, which is meant to carry the 1 Hz strobe.

Top module: `wdg_top`

## Requirements
- R1: A count of zero means stopped: it is never decremented, no timeout fires from it, and the reset output stays high. The count leaves zero only through a write of the value register (0x11).
- R2: A write to the value register (0x11) loads the written byte into the counter, which restarts or stops the countdown; a read of 0x11 returns the current count.
- R3: A read of the status register (0x01) clears the count to zero in the cycle of the read.
- R4: Control bit 7 enables counting. When it is 1, each selected tick lowers a nonzero count by exactly one. When it is 0, ticks leave the count unchanged.
- R5: Control bits 1:0 choose which entry of `tick_i` is the tick source. Setting 2'b10 selects `tick_i[2]`. Strobes on unselected entries have no effect on the count.
- R6: When a selected tick meets a count of one, the count becomes zero and the flag (status bit 6) is set at that clock edge. This happens once per arming; later ticks fire nothing.
- R7: If control bit 6 was 1 at the expiring edge, `wdt_rst_n` goes low at that edge for exactly RST_CYCLES clock cycles. If bit 6 was 0, `wdt_rst_n` stays high.
- R8: Writing status with bit 6 = 0 clears the flag, and writing bit 6 = 1 leaves it unchanged. A timeout in the same cycle as a clearing write leaves the flag set.
- R9: A value-register write in the same cycle as the final tick wins: the new value is loaded and no timeout fires. A status read in the same cycle as the final tick also prevents the timeout.
- R10: `bus_rdata` is updated at the clock edge that samples `bus_rd`, so it is visible one cycle after the read strobe. The control register reads back with bits 7:6 and 1:0 as written and 0 elsewhere. Status reads as the flag at bit 6 and 0 elsewhere. Unmapped addresses read 0.
- R11: After reset the count, control and flag are 0, `wdt_rst_n` is 1 and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| tick_i | input | NUM_TICK | One-cycle tick strobes, one per source |
| wdt_flag | output | 1 | Sticky watchdog timeout flag |
| wdt_rst_n | output | 1 | Active-low timed reset output |

## Verification
Some behaviour is checked by properties on every cycle:
- a stopped count staying at zero;
- a reload taking the written value;
- a status read leaving the count at zero;
- the count never moving by more than one step;
- the flag staying set until a clearing write;
- the flag rising only from a count of one;
- the reset output falling only with the flag set and only when routing was enabled;
- the reset pulse never lasting longer than RST_CYCLES.

Other behaviour can only be shown by the bench's scenarios:
- that the reset pulse lasts exactly RST_CYCLES;
- that unselected tick entries are ignored;
- that a disabled counter freezes;
- the same-cycle priority cases;
- the exact readback encodings.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Width of the tick-source select field in the control register.
  localparam int TSEL_W     = 2;

  // Control register bit positions.
  localparam int CFG_EN_POS = 7;   // count enable
  localparam int CFG_RT_POS = 6;   // route timeout to reset output

  // Status register bit position of the timeout flag.
  localparam int FLAG_POS   = 6;

  typedef struct packed {
    logic              enable;
    logic              route;
    logic [TSEL_W-1:0] tick_sel;
  } wdg_cfg_t;

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h10,
  parameter logic [ADDR_W-1:0] VALUE_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              expire_i,
  output wdg_cfg_t          cfg_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic              clear_o,
  output logic              flag_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic hit_ctrl, hit_value, hit_status;
  logic flag_clr;
  logic [DATA_W-1:0] rd_mux;

  assign hit_ctrl   = (bus_addr == CTRL_ADDR);
  assign hit_value  = (bus_addr == VALUE_ADDR);
  assign hit_status = (bus_addr == STATUS_ADDR);

  // Keepalive reload and the status-read side effect.
  assign load_o     = bus_wr && hit_value;
  assign load_val_o = bus_wdata;
  assign clear_o    = bus_rd && hit_status;

  // Only a zero in the flag position clears the flag.
  assign flag_clr   = bus_wr && hit_status && !bus_wdata[FLAG_POS];

  // Configuration register: only the implemented fields are stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o <= '0;
    end else if (bus_wr && hit_ctrl) begin
      cfg_o.enable   <= bus_wdata[CFG_EN_POS];
      cfg_o.route    <= bus_wdata[CFG_RT_POS];
      cfg_o.tick_sel <= bus_wdata[TSEL_W-1:0];
    end
  end

  // Sticky flag: a timeout outranks a clearing write in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
    end else if (expire_i) begin
      flag_o <= 1'b1;
    end else if (flag_clr) begin
      flag_o <= 1'b0;
    end
  end

  // Read multiplexer, built from current state.
  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[CFG_EN_POS]   = cfg_o.enable;
      rd_mux[CFG_RT_POS]   = cfg_o.route;
      rd_mux[TSEL_W-1:0]   = cfg_o.tick_sel;
    end else if (hit_value) begin
      rd_mux = cnt_i;
    end else if (hit_status) begin
      rd_mux[FLAG_POS] = flag_o;
    end
  end

  // Registered read data, held between reads.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (bus_rd) begin
      rdata_o <= rd_mux;
    end
  end

endmodule

// File: rtl/wdg_tick_sel.sv
module wdg_tick_sel
  import wdg_pkg::*;
#(
  parameter int NUM_TICK = 4
) (
  input  logic [NUM_TICK-1:0] tick_i,
  input  logic [TSEL_W-1:0]   sel_i,
  output logic                tick_o
);

  generate
    if (NUM_TICK == 1) begin : g_single
      // A single source is always the selected one.
      logic unused_sel;
      assign unused_sel = ^sel_i;
      assign tick_o = tick_i[0];
    end else begin : g_mux
      // Select codes with no source behind them yield no tick.
      always_comb begin
        tick_o = 1'b0;
        for (int i = 0; i < NUM_TICK; i++) begin
          if (sel_i == TSEL_W'(i)) tick_o = tick_i[i];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             clear_i,
  input  logic             enable_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic step;

  // Zero is the stopped state: it never steps.
  assign step     = enable_i && tick_i && (cnt_o != '0);

  // The final step fires only when no reload or clear overrides it.
  assign expire_o = step && (cnt_o == CNT_W'(1)) && !load_i && !clear_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (load_i) begin
      cnt_o <= load_val_i;
    end else if (clear_i) begin
      cnt_o <= '0;
    end else if (step) begin
      cnt_o <= cnt_o - CNT_W'(1);
    end
  end

endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic rst_n_o
);

  localparam int PCNT_W = $clog2(PULSE_CYCLES + 1);

  logic [PCNT_W-1:0] left_q;

  // The output drops at the firing edge and returns high PULSE_CYCLES edges later.
  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      rst_n_o <= 1'b1;
    end else if (fire_i) begin
      left_q  <= PCNT_W'(PULSE_CYCLES);
      rst_n_o <= 1'b0;
    end else begin
      if (left_q != '0) left_q <= left_q - PCNT_W'(1);
      rst_n_o <= !(left_q > PCNT_W'(1));
    end
  end

endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                CNT_W       = 8,
  parameter int                NUM_TICK    = 4,
  parameter int                RST_CYCLES  = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h10,
  parameter logic [ADDR_W-1:0] VALUE_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CNT_W-1:0]    bus_wdata,
  output logic [CNT_W-1:0]    bus_rdata,
  input  logic [NUM_TICK-1:0] tick_i,
  output logic                wdt_flag,
  output logic                wdt_rst_n
);

  wdg_cfg_t         cfg_w;
  logic             load_w;
  logic [CNT_W-1:0] load_val_w;
  logic             clear_w;
  logic [CNT_W-1:0] cnt_w;
  logic             expire_w;
  logic             tick_w;
  logic             fire_w;

  wdg_regs #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (CNT_W),
    .CTRL_ADDR  (CTRL_ADDR),
    .VALUE_ADDR (VALUE_ADDR),
    .STATUS_ADDR(STATUS_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_i     (cnt_w),
    .expire_i  (expire_w),
    .cfg_o     (cfg_w),
    .load_o    (load_w),
    .load_val_o(load_val_w),
    .clear_o   (clear_w),
    .flag_o    (wdt_flag),
    .rdata_o   (bus_rdata)
  );

  wdg_tick_sel #(
    .NUM_TICK(NUM_TICK)
  ) u_tick_sel (
    .tick_i(tick_i),
    .sel_i (cfg_w.tick_sel),
    .tick_o(tick_w)
  );

  wdg_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_w),
    .load_val_i(load_val_w),
    .clear_i   (clear_w),
    .enable_i  (cfg_w.enable),
    .tick_i    (tick_w),
    .cnt_o     (cnt_w),
    .expire_o  (expire_w)
  );

  // Routing is taken from the configuration in force at the expiring edge.
  assign fire_w = expire_w && cfg_w.route;

  wdg_rst_pulse #(
    .PULSE_CYCLES(RST_CYCLES)
  ) u_rst_pulse (
    .clk    (clk),
    .rst    (rst),
    .fire_i (fire_w),
    .rst_n_o(wdt_rst_n)
  );

endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
  parameter int                ADDR_W      = 8,
  parameter int                CNT_W       = 8,
  parameter int                RST_CYCLES  = 16,
  parameter logic [ADDR_W-1:0] VALUE_ADDR  = 8'h11,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h01
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic [CNT_W-1:0]  cnt,
  input logic              load,
  input logic              clear,
  input logic              route,
  input logic              wdt_flag,
  input logic              wdt_rst_n
);

  logic val_wr, st_rd, st_clr;
  int   low_run;

  assign val_wr = bus_wr && (bus_addr == VALUE_ADDR);
  assign st_rd  = bus_rd && (bus_addr == STATUS_ADDR);
  assign st_clr = bus_wr && (bus_addr == STATUS_ADDR) && !bus_wdata[6];

  // Length of the current low run on the reset output.
  always_ff @(posedge clk) begin
    if (rst || wdt_rst_n) low_run <= 0;
    else                  low_run <= low_run + 1;
  end

  p_stopped_holds_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) && !val_wr |=> (cnt == '0));

  p_reload_value_r2: assert property (@(posedge clk) disable iff (rst)
    val_wr |=> (cnt == $past(bus_wdata)));

  p_status_read_stops_r3: assert property (@(posedge clk) disable iff (rst)
    st_rd && !val_wr |=> (cnt == '0));

  p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) && !load && !clear |=>
      ((cnt == $past(cnt)) || (cnt == $past(cnt) - CNT_W'(1))));

  p_flag_from_one_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_flag) |-> ($past(cnt) == CNT_W'(1)));

  p_reset_with_flag_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_rst_n) |-> (wdt_flag && $past(route)));

  p_reset_width_r7: assert property (@(posedge clk) disable iff (rst)
    low_run <= RST_CYCLES);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    wdt_flag && !st_clr |=> wdt_flag);

endmodule

bind wdg_top wdg_chk #(
  .ADDR_W     (ADDR_W),
  .CNT_W      (CNT_W),
  .RST_CYCLES (RST_CYCLES),
  .VALUE_ADDR (VALUE_ADDR),
  .STATUS_ADDR(STATUS_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .cnt      (cnt_w),
  .load     (load_w),
  .clear    (clear_w),
  .route    (cfg_w.route),
  .wdt_flag (wdt_flag),
  .wdt_rst_n(wdt_rst_n)
);

// File: tb/tb_wdg_top.sv
`timescale 1ns/1ps
module tb_wdg_top;

  localparam int RSTC = 16;
  localparam logic [7:0] A_CTRL = 8'h10, A_VAL = 8'h11, A_ST = 8'h01;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [3:0] tick_i = 4'h0;
  logic       wdt_flag, wdt_rst_n;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;
  bit live = 0;

  always #2.5 clk = ~clk;

  wdg_top #(.RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_i(tick_i), .wdt_flag(wdt_flag), .wdt_rst_n(wdt_rst_n)
  );

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_ctrl, m_flag, m_left, m_rdata;

  always @(posedge clk) begin
    int tick_sel, tk, ld, clr, expire, new_cnt;
    if (rst) begin
      m_cnt = 0; m_ctrl = 0; m_flag = 0; m_left = 0; m_rdata = 0;
    end else begin
      tick_sel = m_ctrl & 3;
      tk  = tick_i[tick_sel];
      ld  = bus_wr && bus_addr == A_VAL;
      clr = bus_rd && bus_addr == A_ST;
      if (bus_rd) begin
        if (bus_addr == A_CTRL)     m_rdata = m_ctrl;
        else if (bus_addr == A_VAL) m_rdata = m_cnt;
        else if (bus_addr == A_ST)  m_rdata = m_flag ? 64 : 0;
        else                        m_rdata = 0;
      end
      expire = !ld && !clr && ((m_ctrl & 128) != 0) && tk && m_cnt == 1;
      if (ld) new_cnt = bus_wdata;
      else if (clr) new_cnt = 0;
      else if (((m_ctrl & 128) != 0) && tk && m_cnt > 0) new_cnt = m_cnt - 1;
      else new_cnt = m_cnt;
      if (expire && ((m_ctrl & 64) != 0)) m_left = RSTC;
      else if (m_left > 0) m_left = m_left - 1;
      if (expire) m_flag = 1;
      else if (bus_wr && bus_addr == A_ST && !bus_wdata[6]) m_flag = 0;
      if (bus_wr && bus_addr == A_CTRL) m_ctrl = bus_wdata & 8'hC3;
      m_cnt = new_cnt;
      live = 1;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (live && !rst && !done) begin
      compared += 3;
      if (wdt_rst_n !== (m_left == 0)) begin
        mismatched++;
        $display("FAIL R7 model rst_n act=%0d exp=%0d t=%0t", wdt_rst_n, m_left == 0, $time);
      end
      if (wdt_flag !== m_flag[0]) begin
        mismatched++;
        $display("FAIL R6 model flag act=%0d exp=%0d t=%0t", wdt_flag, m_flag, $time);
      end
      if (bus_rdata !== m_rdata[7:0]) begin
        mismatched++;
        $display("FAIL R10 model rdata act=%0h exp=%0h t=%0t", bus_rdata, m_rdata, $time);
      end
    end
  end

  // Watchdog on the bench itself.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic tk(input int idx);
    @(negedge clk); tick_i[idx] = 1'b1;
    @(negedge clk); tick_i = 4'h0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int d, n;
    repeat (3) @(negedge clk);
    rst = 0;
    idle(1);

    // R11 reset state
    chk("R11 rst_n", wdt_rst_n, 1);
    chk("R11 flag", wdt_flag, 0);
    chk("R11 rdata", bus_rdata, 0);
    rd(A_CTRL, d); chk("R11 ctrl", d, 0);
    rd(A_VAL, d);  chk("R11 count", d, 0);

    // R10 control readback masks unimplemented bits
    wr(A_CTRL, 8'hFF); rd(A_CTRL, d); chk("R10 ctrl readback", d, 8'hC3);

    // R2 R4 R5 R6 R7 basic countdown on the 1 Hz entry
    wr(A_CTRL, 8'hC2);
    wr(A_VAL, 8'd3);
    rd(A_VAL, d); chk("R2 load", d, 3);
    tk(2);
    rd(A_VAL, d); chk("R4 one step", d, 2);
    tk(2);
    tk(2);
    chk("R6 flag set", wdt_flag, 1);
    chk("R7 reset low", wdt_rst_n, 0);
    n = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wdt_rst_n == 1'b0) n++; else break;
    end
    chk("R7 pulse width", n, RSTC);
    rd(A_VAL, d); chk("R6 count stays zero", d, 0);

    // R1 stopped count ignores ticks, no second pulse
    tk(2); tk(2); idle(2);
    chk("R1 no refire", wdt_rst_n, 1);
    rd(A_VAL, d); chk("R1 zero holds", d, 0);

    // R10 status readback, R8 flag clear rules
    rd(A_ST, d); chk("R10 status", d, 8'h40);
    wr(A_ST, 8'h40); rd(A_ST, d); chk("R8 write one keeps", d, 8'h40);
    wr(A_ST, 8'hBF); rd(A_ST, d); chk("R8 write zero clears", d, 0);

    // R5 unselected entries ignored, other select works
    wr(A_VAL, 8'd5);
    tk(0); tk(1); tk(3);
    rd(A_VAL, d); chk("R5 unselected ignored", d, 5);
    wr(A_CTRL, 8'hC1);
    tk(1);
    rd(A_VAL, d); chk("R5 select entry 1", d, 4);

    // R4 disable freezes the count
    wr(A_CTRL, 8'h41);
    tk(1); tk(1);
    rd(A_VAL, d); chk("R4 disabled frozen", d, 4);

    // R3 status read stops the watchdog
    wr(A_CTRL, 8'hC2);
    rd(A_ST, d);
    rd(A_VAL, d); chk("R3 status read clears", d, 0);
    tk(2); rd(A_VAL, d); chk("R3 stays stopped", d, 0);

    // R7 routing off: flag but no reset
    wr(A_CTRL, 8'h82);
    wr(A_VAL, 8'd1);
    tk(2);
    chk("R7 route off flag", wdt_flag, 1);
    chk("R7 route off rst_n", wdt_rst_n, 1);
    idle(2);
    chk("R7 route off rst_n later", wdt_rst_n, 1);
    wr(A_ST, 8'h00);

    // R9 write beats final tick
    wr(A_CTRL, 8'hC2);
    wr(A_VAL, 8'd1);
    @(negedge clk); bus_wr = 1; bus_addr = A_VAL; bus_wdata = 8'd4; tick_i[2] = 1;
    @(negedge clk); bus_wr = 0; tick_i = 0;
    chk("R9 write wins flag", wdt_flag, 0);
    chk("R9 write wins rst_n", wdt_rst_n, 1);
    rd(A_VAL, d); chk("R9 write wins count", d, 4);

    // R9 status read beats final tick
    wr(A_VAL, 8'd1);
    @(negedge clk); bus_rd = 1; bus_addr = A_ST; tick_i[2] = 1;
    @(negedge clk); bus_rd = 0; tick_i = 0;
    chk("R9 read wins flag", wdt_flag, 0);
    rd(A_VAL, d); chk("R9 read wins count", d, 0);

    // R8 timeout beats a clearing write
    wr(A_CTRL, 8'h82);
    wr(A_VAL, 8'd1);
    @(negedge clk); bus_wr = 1; bus_addr = A_ST; bus_wdata = 8'h00; tick_i[2] = 1;
    @(negedge clk); bus_wr = 0; tick_i = 0;
    chk("R8 set wins", wdt_flag, 1);

    // R2 keepalive keeps it from expiring
    wr(A_ST, 8'h00);
    wr(A_CTRL, 8'hC2);
    wr(A_VAL, 8'd2);
    tk(2); wr(A_VAL, 8'd2); tk(2); wr(A_VAL, 8'd2); tk(2);
    chk("R2 keepalive no flag", wdt_flag, 0);
    rd(A_VAL, d); chk("R2 keepalive count", d, 1);

    // R10 unmapped address reads zero
    rd(8'h33, d); chk("R10 unmapped", d, 0);

    idle(3);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule